// File: doc/BRIEF.md
# Half-Duplex Boot Flash SPI Controller

This block is a register-mapped SPI master for a boot NOR flash. Software sees three 32-bit registers on a simple select/write bus: a configuration word holding two byte-order flags, a control/status word holding the chip-select level, the burst length and a ready flag, and a data window. A write to the data window shifts one or four bytes out on MOSI. A read of the data window shifts one or four bytes in from MISO, stalling the bus until the bytes have arrived. A transfer only ever transmits or receives, never both at once.

The chip-select pin follows a register bit level for level, so software frames a flash command by clearing that bit, issuing any number of data accesses and setting it again. SCK is the system clock divided by a fixed parameter and idles low. Data moves MSB first in SPI mode 0. Single-byte transfers always use the top byte lane of the data word.

Top module: `bootflash_spi`

## Requirements
- R1: After reset the configuration register reads 0x00000000 and the control/status register reads 0xC8000000, with spi_cs0_n high and spi_sck and spi_mosi low.
- R2: Registers are decoded by byte offset. Offset 0x0 is configuration (bit 28 read big-endian, bit 27 write big-endian). Offset 0x8 is control/status (bit 31 select-0 level, bit 30 select-1 level, bits 29:28 length, bit 27 ready, bit 24 select choice). Offset 0xC is data. Writable bits read back as written, and all other bits and offsets read zero.
- R3: spi_cs0_n always equals control/status bit 31 and changes only when that register is written, never because of a data access.
- R4: A length code of 3 moves 32 bits. Codes 0, 1 and 2 move 8 bits.
- R5: An 8-bit transmit sends bits 31:24 of the written word, MSB first. A 32-bit transmit sends bits 31..0 when write big-endian is 1. When it is 0, the bytes go out from bits 7:0 up to bits 31:24, each byte MSB first.
- R6: An 8-bit receive returns the byte in bits 31:24, with bits 23:0 zero. In a 32-bit receive, the first wire byte lands in bits 31:24 when read big-endian is 1 and in bits 7:0 when it is 0.
- R7: SPI mode 0. SCK idles low, each SCK half period lasts CLK_DIV clocks, MOSI changes only at start or on a falling SCK, and MISO is sampled on the rising SCK.
- R8: The ready bit drops at the clock edge that accepts a data access and returns high after 2*CLK_DIV*bits clocks.
- R9: During a receive, MOSI stays low.
- R10: A data read holds bus_wait high until its shift completes. With an idle shifter this lasts 2*CLK_DIV*bits+1 cycles, and the data is presented in the first cycle with bus_wait low. A read issued while a transmit is running first waits for that transmit to end.
- R11: A data write while ready is 0 is ignored and does not alter the transfer in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_wait is low |
| bus_wait | output | 1 | Stall of a data read in progress |
| spi_sck | output | 1 | Serial clock |
| spi_cs0_n | output | 1 | Active-low flash select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A data write is accepted at one edge, and the ready bit is then low for exactly 2*CLK_DIV*bits cycles, so the bench polls the status register at each falling clock edge and compares the count of low samples with that number. A data read counts its bus_wait-high samples, which are 2*CLK_DIV*bits+1 when idle and include the remaining transmit time when issued behind a write, and it takes the read data in the first cycle with bus_wait low. Wire bits are captured by a flash model on rising SCK and checked only after ready returns. The sweep covers every length code against every byte-order setting in both directions.

// File: rtl/bootflash_spi_pkg.sv
`timescale 1ns/1ps
package bootflash_spi_pkg;
    localparam int WORD_W = 32;
    localparam int CNT_W  = $clog2(WORD_W);

    localparam int OFS_CFG = 'h0;
    localparam int OFS_CSR = 'h8;
    localparam int OFS_DAT = 'hC;

    localparam int LEN_WIDE = 3;

    typedef enum logic [1:0] {SEL_NONE, SEL_CFG, SEL_CSR, SEL_DAT} sel_e;

    typedef struct packed {
        logic rd_big;
        logic wr_big;
    } cfg_t;

    typedef struct packed {
        logic       cs0;
        logic       cs1;
        logic [1:0] len;
        logic       csel;
    } csr_t;

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic is_wide(input logic [1:0] len);
        return len == 2'(LEN_WIDE);
    endfunction
endpackage

// File: rtl/bootflash_spi_regs.sv
`timescale 1ns/1ps
module bootflash_spi_regs
    import bootflash_spi_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        wr_hi,
    input  logic              ready,
    output cfg_t              cfg_q,
    output csr_t              csr_q,
    output sel_e              hit,
    output logic [WORD_W-1:0] reg_rdata
);
    logic wr_cfg, wr_csr;
    logic unused_bits;

    always_comb begin
        if (bus_addr == ADDR_W'(OFS_CFG))      hit = SEL_CFG;
        else if (bus_addr == ADDR_W'(OFS_CSR)) hit = SEL_CSR;
        else if (bus_addr == ADDR_W'(OFS_DAT)) hit = SEL_DAT;
        else                                   hit = SEL_NONE;
    end

    assign wr_cfg = bus_sel && bus_we && hit == SEL_CFG;
    assign wr_csr = bus_sel && bus_we && hit == SEL_CSR;
    assign unused_bits = ^wr_hi[2:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            csr_q <= '{cs0: 1'b1, cs1: 1'b1, len: 2'd0, csel: 1'b0};
        end else begin
            if (wr_cfg) cfg_q <= '{rd_big: wr_hi[4], wr_big: wr_hi[3]};
            if (wr_csr) csr_q <= '{cs0: wr_hi[7], cs1: wr_hi[6], len: wr_hi[5:4], csel: wr_hi[0]};
        end
    end

    always_comb begin
        case (hit)
            SEL_CFG: reg_rdata = {3'b000, cfg_q.rd_big, cfg_q.wr_big, 27'd0};
            SEL_CSR: reg_rdata = {csr_q.cs0, csr_q.cs1, csr_q.len, ready, 2'b00, csr_q.csel, 24'd0};
            default: reg_rdata = '0;
        endcase
    end

    // R3
    cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_csr |=> $stable(csr_q.cs0));
endmodule

// File: rtl/bootflash_spi_lanes.sv
`timescale 1ns/1ps
module bootflash_spi_lanes
    import bootflash_spi_pkg::*;
(
    input  cfg_t              cfg_q,
    input  logic              tx_wide,
    input  logic              rx_wide,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] rx_raw,
    output logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] rx_word
);
    always_comb begin
        if (tx_wide && !cfg_q.wr_big) tx_word = swap_bytes(wdata);
        else                          tx_word = wdata;

        if (!rx_wide)           rx_word = {rx_raw[7:0], 24'd0};
        else if (cfg_q.rd_big)  rx_word = rx_raw;
        else                    rx_word = swap_bytes(rx_raw);
    end
endmodule

// File: rtl/bootflash_spi_shifter.sv
`timescale 1ns/1ps
module bootflash_spi_shifter
    import bootflash_spi_pkg::*;
#(
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_rx,
    input  logic              start_wide,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              busy,
    output logic              wide_q,
    output logic              sck,
    output logic              mosi,
    output logic              rx_fin,
    output logic [WORD_W-1:0] rx_raw
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic              is_rx;
    logic [DIV_W-1:0]  divcnt;
    logic [CNT_W-1:0]  bitcnt;
    logic [WORD_W-1:0] txsr;
    logic              half_end;

    assign half_end = busy && divcnt == DIV_W'(CLK_DIV - 1);
    assign rx_fin   = half_end && sck && bitcnt == '0 && is_rx;
    assign mosi     = busy && !is_rx && txsr[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            sck    <= 1'b0;
            is_rx  <= 1'b0;
            wide_q <= 1'b0;
            divcnt <= '0;
            bitcnt <= '0;
            txsr   <= '0;
            rx_raw <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            sck    <= 1'b0;
            is_rx  <= start_rx;
            wide_q <= start_wide;
            divcnt <= '0;
            bitcnt <= start_wide ? CNT_W'(WORD_W - 1) : CNT_W'(7);
            txsr   <= start_rx ? '0 : tx_word;
            rx_raw <= '0;
        end else if (busy) begin
            if (half_end) begin
                divcnt <= '0;
                sck    <= !sck;
                if (!sck) begin
                    rx_raw <= {rx_raw[WORD_W-2:0], miso};
                end else if (bitcnt == '0) begin
                    busy <= 1'b0;
                end else begin
                    bitcnt <= bitcnt - 1'b1;
                    txsr   <= {txsr[WORD_W-2:0], 1'b0};
                end
            end else begin
                divcnt <= divcnt + 1'b1;
            end
        end
    end

    // R7
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck);

    // R7
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sck) |-> $stable(mosi));
endmodule

// File: rtl/bootflash_spi.sv
`timescale 1ns/1ps
module bootflash_spi
    import bootflash_spi_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_wait,
    output logic              spi_sck,
    output logic              spi_cs0_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    cfg_t              cfg_q;
    csr_t              csr_q;
    sel_e              hit;
    logic [WORD_W-1:0] reg_rdata, tx_word, rx_word, rx_raw;
    logic              busy, wide_q, rx_fin, rx_hold;
    logic              dat_acc, dat_wr, dat_rd, start, cur_wide;

    assign dat_acc  = bus_sel && hit == SEL_DAT;
    assign dat_wr   = dat_acc && bus_we;
    assign dat_rd   = dat_acc && !bus_we;
    assign start    = (dat_wr || (dat_rd && !rx_hold)) && !busy;
    assign cur_wide = is_wide(csr_q.len);

    bootflash_spi_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .wr_hi(bus_wdata[31:24]), .ready(!busy),
        .cfg_q(cfg_q), .csr_q(csr_q), .hit(hit), .reg_rdata(reg_rdata));

    bootflash_spi_lanes lanes_i (
        .cfg_q(cfg_q), .tx_wide(cur_wide), .rx_wide(wide_q),
        .wdata(bus_wdata), .rx_raw(rx_raw), .tx_word(tx_word), .rx_word(rx_word));

    bootflash_spi_shifter #(.CLK_DIV(CLK_DIV)) shift_i (
        .clk(clk), .rst(rst), .start(start), .start_rx(!bus_we),
        .start_wide(cur_wide), .tx_word(tx_word), .miso(spi_miso),
        .busy(busy), .wide_q(wide_q), .sck(spi_sck), .mosi(spi_mosi),
        .rx_fin(rx_fin), .rx_raw(rx_raw));

    always_ff @(posedge clk) begin
        if (rst)                     rx_hold <= 1'b0;
        else if (rx_fin)             rx_hold <= 1'b1;
        else if (dat_rd && rx_hold)  rx_hold <= 1'b0;
    end

    assign bus_wait  = dat_rd && !rx_hold;
    assign bus_rdata = (hit == SEL_DAT) ? rx_word : reg_rdata;
    assign spi_cs0_n = csr_q.cs0;

    // R8
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && !busy) |=> busy);

    // R10
    wait_release_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_wait) && bus_sel) |-> $fell(busy));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rx_hold |-> !busy);
endmodule

// File: tb/bootflash_spi_tb_top.sv
`timescale 1ns/1ps
module bootflash_spi_tb_top;
    localparam int AW  = 4;
    localparam int DIV = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_wait, spi_sck, spi_cs0_n, spi_mosi, spi_miso;

    always #10 clk = ~clk;

    bootflash_spi #(.ADDR_W(AW), .CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_wait(bus_wait), .spi_sck(spi_sck), .spi_cs0_n(spi_cs0_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    // flash model: captures MOSI on rising SCK, serves pattern on MISO
    int          fall_cnt = 0, rise_cnt = 0, base = 0;
    logic [31:0] cap = '0, pat = '0;

    always @(negedge spi_sck) fall_cnt = fall_cnt + 1;
    always @(posedge spi_sck) begin
        cap = {cap[30:0], spi_mosi};
        rise_cnt = rise_cnt + 1;
    end
    always_comb begin
        if (fall_cnt - base >= 0 && fall_cnt - base < 32) spi_miso = pat[31 - (fall_cnt - base)];
        else spi_miso = 1'b0;
    end

    int total = 0, bad = 0;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] swp(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] csr_word(input logic cs0, input logic [1:0] len);
        return {cs0, 1'b1, len, 3'b000, 1'b1, 24'd0};
    endfunction

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_ready(output int cnt);
        bit done = 0;
        cnt = 0;
        while (!done) begin
            bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'h8;
            #1;
            if (bus_rdata[27]) done = 1;
            else begin cnt++; @(negedge clk); end
        end
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic dat_rd(output logic [31:0] d, output int stall);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'hC;
        #1 stall = 0;
        while (bus_wait) begin stall++; @(negedge clk); #1; end
        d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=done", 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d, w, a, b;
        int cnt, stall, nb, r0;
        repeat (3) @(negedge clk);
        check("R1", "cs0_n in reset", {31'd0, spi_cs0_n}, 32'd1);
        check("R1", "sck in reset", {31'd0, spi_sck}, 32'd0);
        check("R1", "mosi in reset", {31'd0, spi_mosi}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        bus_rd(4'h8, d); check("R1", "csr reset", d, 32'hC800_0000);
        bus_rd(4'h0, d); check("R1", "cfg reset", d, 32'h0);
        bus_rd(4'h4, d); check("R2", "unmapped read", d, 32'h0);
        bus_wr(4'h8, csr_word(1'b0, 2'd2) | 32'h0300_FFFF);
        bus_rd(4'h8, d); check("R2", "csr readback", d, csr_word(1'b0, 2'd2) | 32'h0800_0000);
        check("R3", "cs0_n follows bit 31", {31'd0, spi_cs0_n}, 32'd0);
        bus_wr(4'h0, 32'hFFFF_FFFF);
        bus_rd(4'h0, d); check("R2", "cfg readback", d, 32'h1800_0000);

        for (int o = 0; o < 4; o++) begin
            for (int len = 0; len < 4; len++) begin
                for (int i = 0; i < 3; i++) begin
                    nb = (len == 3) ? 32 : 8;
                    bus_wr(4'h0, {3'b000, o[1], o[0], 27'd0});
                    bus_wr(4'h8, csr_word(1'b0, 2'(len)));
                    w = (32'h1A2B_3C4D * (i + 1)) ^ (32'h9E37_79B9 * (o * 4 + len + 1));
                    r0 = rise_cnt;
                    bus_wr(4'hC, w);
                    wait_ready(cnt);
                    check("R8", "tx ready-low cycles", cnt, 2 * DIV * nb);
                    check("R4", "tx sck rises", rise_cnt - r0, nb);
                    if (nb == 8) check("R5", "tx byte", {24'd0, cap[7:0]}, {24'd0, w[31:24]});
                    else         check("R5", "tx word", cap, o[0] ? w : swp(w));
                    check("R3", "cs0_n after tx", {31'd0, spi_cs0_n}, 32'd0);
                    check("R7", "sck idle after tx", {31'd0, spi_sck}, 32'd0);

                    pat = ~w ^ {w[15:0], w[31:16]};
                    base = fall_cnt;
                    r0 = rise_cnt;
                    dat_rd(d, stall);
                    check("R10", "rx stall cycles", stall, 2 * DIV * nb + 1);
                    check("R4", "rx sck rises", rise_cnt - r0, nb);
                    if (nb == 8) check("R6", "rx byte", d, {pat[31:24], 24'd0});
                    else         check("R6", "rx word", d, o[1] ? pat : swp(pat));
                    if (nb == 8) check("R9", "mosi low in rx", {24'd0, cap[7:0]}, 32'd0);
                    else         check("R9", "mosi low in rx", cap, 32'd0);
                end
            end
        end

        // R11: second write while busy is dropped
        bus_wr(4'h0, 32'h1800_0000);
        bus_wr(4'h8, csr_word(1'b0, 2'd3));
        a = 32'hC0DE_F00D; b = 32'h1234_5678;
        r0 = rise_cnt;
        bus_wr(4'hC, a);
        bus_wr(4'hC, b);
        wait_ready(cnt);
        check("R11", "ready-low cycles with dropped write", cnt, 2 * DIV * 32 - 1);
        check("R11", "sck rises with dropped write", rise_cnt - r0, 32);
        check("R11", "wire word with dropped write", cap, a);

        // R10: read issued behind a running transmit
        pat = 32'h5AA5_3CC3;
        bus_wr(4'hC, 32'h0F0F_F0F0);
        base = fall_cnt + 32;
        dat_rd(d, stall);
        check("R10", "stall behind tx", stall, 2 * DIV * 32 + 1 + 2 * DIV * 32);
        check("R10", "data behind tx", d, pat);

        bus_wr(4'h8, csr_word(1'b1, 2'd0));
        check("R3", "cs0_n deselect", {31'd0, spi_cs0_n}, 32'd1);
        pat = 32'h8100_0000; base = fall_cnt;
        dat_rd(d, stall);
        check("R3", "cs0_n held across read", {31'd0, spi_cs0_n}, 32'd1);
        check("R6", "rx byte while deselected", d, 32'h8100_0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule